// File: doc/BRIEF.md
# Serial-to-Parallel Word Deserializer with Bit-Slip Alignment

This block turns a serial bit stream, sampled one bit per edge of a fast clock, into parallel words of `J` bits. An internal phase counter issues one word strobe every `J` fast-clock cycles. The core side of the block is the set of registers that advance only on that strobe, so one word period is one core cycle. On each strobe the newest `J` serial bits enter a two-word history register. The output word is a `J`-bit window taken from that history.

Word alignment is controlled by a slip request input. The block counts each rising edge of the request, sampled on a strobe, and each counted edge moves the window one bit later in the stream. This adds one bit of serial latency. Once the offset has reached `J-1`, the next slip wraps it to zero, because an offset of `J` bits is the same word boundary as zero. A status flag reports that the offset sits at its last value. The flag follows the offset with a delay of four core cycles.

An asynchronous slip-reset input returns the offset to zero without a clock and drops the status flag. Alignment logic outside the block watches the words and issues slips until it sees its marker pattern.

Top module: `deser_bitslip`

## Requirements
- R1: `word_strobe` is high for exactly one fast-clock cycle in every `J` (parameter, 3 to 10). `word_out` is `J` bits wide and changes only on the cycle where `word_strobe` goes high.
- R2: With zero slip offset, strobe number m (counted from 0 after reset) delivers serial bits mJ to mJ+J-1, counted from the first edge after reset. The earliest of these bits is at `word_out[J-1]` and the latest at bit 0.
- R3: With slip offset s, strobe m delivers serial bits mJ-s to mJ+J-1-s in the same MSB-first order. Bits before the start of the stream read as 0.
- R4: The slip request is sampled on strobe edges and only a 0-to-1 change counts. A request held high over several strobes adds exactly one bit of latency.
- R5: The offset runs from 0 to J-1. A counted slip at offset J-1 returns it to 0, which is the zero-latency alignment.
- R6: `slip_max` shows whether the offset equalled J-1 four strobes earlier. It therefore rises on the fourth strobe after the slip that reached J-1, and it changes only together with a strobe or a slip reset.
- R7: Asserting `slip_rst` (active high, asynchronous) sets the offset to 0 and clears `slip_max` at once, with no clock edge needed.
- R8: While the synchronous `rst` is high, `word_out`, `word_strobe` and `slip_max` are 0 and the offset is 0.
- R9: A slip counted on a strobe edge leaves the word delivered on that same strobe at the old offset. The new offset applies from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (bit-rate) clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| ser_in | input | 1 | Serial data, one bit per clock |
| slip_req | input | 1 | Slip request; a rising edge seen on a strobe adds one bit of latency |
| slip_rst | input | 1 | Asynchronous active-high clear of the slip offset and status |
| word_out | output | J | Aligned parallel word |
| word_strobe | output | 1 | One-cycle pulse marking a new `word_out` |
| slip_max | output | 1 | Delayed flag: the offset is at J-1 |

## Verification
Two functions can fall on the same strobe: counting a slip and handing out the word of that strobe. The bench provokes this by raising the request on alternate words, so that a slip edge lands on every second strobe. It then checks that each word carries the offset that was in force before its own strobe. The same scenario also pushes slips through offset J-1 while the delayed flag is still high. There the bench judges the wrap to zero and the flag against a four-stage model of its own, and it also checks that a slip reset clears the flag immediately.

// File: rtl/deser_pkg.sv
package deser_pkg;

    // Upper bound on the deserialization factor supported by the shared types.
    localparam int MAX_J     = 10;
    localparam int MIN_J     = 3;
    localparam int HIST_MAX  = 2 * MAX_J;

    typedef logic [MAX_J-1:0]    word_t;
    typedef logic [HIST_MAX-1:0] hist_t;
    typedef logic [3:0]          slip_cnt_t;

    // One parallel word leaving the block together with its strobe.
    typedef struct packed {
        word_t data;
        logic  valid;
    } word_evt_t;

    // Slip bookkeeping advanced on each strobe.
    typedef struct packed {
        slip_cnt_t cnt;
        logic      rise;
    } slip_state_t;

    // Select a J-bit window ending 'off' bits before the newest history bit.
    function automatic word_t pick_window(hist_t h, slip_cnt_t off, int j);
        word_t w;
        w = '0;
        for (int i = 0; i < MAX_J; i++) begin
            if (i < j && (i + int'(off)) < HIST_MAX)
                w[i] = h[i + int'(off)];
        end
        return w;
    endfunction

    // Next slip offset with wrap at the deserialization factor.
    function automatic slip_cnt_t next_offset(slip_cnt_t cur, int j);
        if (int'(cur) >= j - 1)
            return '0;
        return cur + slip_cnt_t'(1);
    endfunction

endpackage

// File: rtl/deser_phase_gen.sv
module deser_phase_gen #(
    parameter int J = 8
) (
    input  logic clk,
    input  logic rst,
    output logic stb
);
    localparam int PW = $clog2(J);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (phase == PW'(J - 1))
            phase <= '0;
        else
            phase <= phase + PW'(1);
    end

    assign stb = (phase == PW'(J - 1));

endmodule

// File: rtl/deser_shift_in.sv
module deser_shift_in #(
    parameter int J = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_in,
    output logic [J-1:0] word_asm
);
    logic [J-2:0] sh;

    // Earlier bits move toward the MSB; the live bit completes the word.
    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else
            sh <= {sh[J-3:0], ser_in};
    end

    assign word_asm = {sh, ser_in};

endmodule

// File: rtl/deser_slip_ctrl.sv
module deser_slip_ctrl
    import deser_pkg::*;
#(
    parameter int J       = 8,
    parameter int MAX_DLY = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      slip_rst,
    input  logic      stb,
    input  logic      slip_req,
    output slip_cnt_t offset,
    output logic      slip_max
);
    logic              req_prev;
    slip_state_t       st;
    logic [MAX_DLY-1:0] max_pipe;
    logic              at_last;

    // Edge detector on the request, evaluated only on strobes.
    always_ff @(posedge clk) begin
        if (rst)
            req_prev <= 1'b0;
        else if (stb)
            req_prev <= slip_req;
    end

    assign st.rise = stb & slip_req & ~req_prev;
    assign at_last = (int'(st.cnt) == J - 1);

    always_ff @(posedge clk or posedge slip_rst) begin
        if (slip_rst) begin
            st.cnt   <= '0;
            max_pipe <= '0;
        end else if (rst) begin
            st.cnt   <= '0;
            max_pipe <= '0;
        end else begin
            if (st.rise)
                st.cnt <= next_offset(st.cnt, J);
            if (stb)
                max_pipe <= {max_pipe[MAX_DLY-2:0], at_last};
        end
    end

    assign offset   = st.cnt;
    assign slip_max = max_pipe[MAX_DLY-1];

endmodule

// File: rtl/deser_window.sv
module deser_window
    import deser_pkg::*;
#(
    parameter int J = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic [J-1:0] word_asm,
    input  slip_cnt_t    offset,
    output logic [J-1:0] word_out,
    output logic         word_strobe
);
    localparam int HW = 2 * J;

    logic [HW-1:0] hist;
    logic [HW-1:0] hist_nx;
    word_t         sel;
    word_evt_t     evt;

    assign hist_nx = {hist[J-1:0], word_asm};
    assign sel     = pick_window(hist_t'(hist_nx), offset, J);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist      <= '0;
            evt.data  <= '0;
            evt.valid <= 1'b0;
        end else begin
            evt.valid <= stb;
            if (stb) begin
                hist     <= hist_nx;
                evt.data <= sel;
            end
        end
    end

    assign word_out    = evt.data[J-1:0];
    assign word_strobe = evt.valid;

endmodule

// File: rtl/deser_bitslip.sv
module deser_bitslip
    import deser_pkg::*;
#(
    parameter int J       = 8,
    parameter int MAX_DLY = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_in,
    input  logic         slip_req,
    input  logic         slip_rst,
    output logic [J-1:0] word_out,
    output logic         word_strobe,
    output logic         slip_max
);
    generate
        if (J < MIN_J || J > MAX_J) begin : g_bad_j
            $error("deser_bitslip: J out of range");
        end
        if (MAX_DLY < 2) begin : g_bad_dly
            $error("deser_bitslip: MAX_DLY below 2");
        end
    endgenerate

    logic         stb;
    logic [J-1:0] word_asm;
    slip_cnt_t    slip_off;

    deser_phase_gen #(.J(J)) phase_i (
        .clk (clk),
        .rst (rst),
        .stb (stb)
    );

    deser_shift_in #(.J(J)) shift_i (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .word_asm (word_asm)
    );

    deser_slip_ctrl #(.J(J), .MAX_DLY(MAX_DLY)) slip_i (
        .clk      (clk),
        .rst      (rst),
        .slip_rst (slip_rst),
        .stb      (stb),
        .slip_req (slip_req),
        .offset   (slip_off),
        .slip_max (slip_max)
    );

    deser_window #(.J(J)) win_i (
        .clk         (clk),
        .rst         (rst),
        .stb         (stb),
        .word_asm    (word_asm),
        .offset      (slip_off),
        .word_out    (word_out),
        .word_strobe (word_strobe)
    );

endmodule

// File: rtl/deser_bitslip_chk.sv
module deser_bitslip_chk
    import deser_pkg::*;
#(
    parameter int J = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         slip_rst,
    input logic         word_strobe,
    input logic [J-1:0] word_out,
    input logic         slip_max,
    input slip_cnt_t    offset
);
    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
        word_strobe |=> !word_strobe); // R1

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !word_strobe |-> $stable(word_out)); // R1

    AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(offset) < J); // R5

    AST_MAX_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(slip_max) |-> word_strobe); // R6

    AST_SLIPRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        slip_rst |-> (offset == '0 && !slip_max)); // R7

endmodule

bind deser_bitslip deser_bitslip_chk #(.J(J)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .slip_rst    (slip_rst),
    .word_strobe (word_strobe),
    .word_out    (word_out),
    .slip_max    (slip_max),
    .offset      (slip_off)
);

// File: tb/deser_bitslip_tb.sv
module deser_bitslip_tb_top;
    localparam int CLK_P = 10;
    localparam int J     = 4;
    localparam int DLY   = 4;
    localparam int NB    = 2000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_in = 1'b0;
    logic         slip_req = 1'b0;
    logic         slip_rst = 1'b0;
    logic [J-1:0] word_out;
    logic         word_strobe;
    logic         slip_max;

    int checks = 0;
    int errors = 0;

    logic bits [NB];
    int   n = 0;
    int   s_model = 0;
    logic prev_model = 1'b0;
    logic pipe_model [DLY];
    logic [J-1:0] exp_word = '0;
    logic         exp_max  = 1'b0;
    string        cur_req  = "R2";

    always #(CLK_P/2) clk = ~clk;

    deser_bitslip #(.J(J), .MAX_DLY(DLY)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .ser_in      (ser_in),
        .slip_req    (slip_req),
        .slip_rst    (slip_rst),
        .word_out    (word_out),
        .word_strobe (word_strobe),
        .slip_max    (slip_max)
    );

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [J-1:0] word_at(int m, int s);
        logic [J-1:0] w;
        for (int i = 0; i < J; i++) begin
            int idx;
            idx = m * J + i - s;
            w[J-1-i] = (idx < 0) ? 1'b0 : bits[idx];
        end
        return w;
    endfunction

    // One fast-clock cycle: judge the previous edge, drive, model the coming edge.
    task automatic cycle(input logic level, input logic do_rst);
        if (n > 0) begin
            if (((n - 1) % J) == J - 1) begin
                check(word_strobe === 1'b1, "R1", 32'(word_strobe), 32'd1);
                check(word_out === exp_word, cur_req, 32'(word_out), 32'(exp_word));
                check(slip_max === exp_max, "R6", 32'(slip_max), 32'(exp_max));
            end else begin
                check(word_strobe === 1'b0, "R1", 32'(word_strobe), 32'd0);
            end
        end
        if (do_rst) begin
            #1 slip_rst = 1'b1;
            #1 check(slip_max === 1'b0, "R7", 32'(slip_max), 32'd0);
            slip_rst = 1'b0;
            s_model = 0;
            exp_max = 1'b0;
            for (int k = 0; k < DLY; k++) pipe_model[k] = 1'b0;
        end
        ser_in   = bits[n];
        slip_req = level;
        if ((n % J) == J - 1) begin
            exp_word = word_at(n / J, s_model);       // R9: old offset used
            for (int k = DLY - 1; k > 0; k--) pipe_model[k] = pipe_model[k-1];
            pipe_model[0] = (s_model == J - 1);
            exp_max = pipe_model[DLY-1];
            if (level && !prev_model)
                s_model = (s_model == J - 1) ? 0 : s_model + 1;  // R5 wrap
            prev_model = level;
        end
        n++;
        @(negedge clk);
    endtask

    task automatic run_words(input int nw, input logic level);
        for (int c = 0; c < nw * J; c++) cycle(level, 1'b0);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++)
            bits[i] = logic'(((i * 13 + (i >> 2) * 5 + 1) % 7) > 2);
        for (int k = 0; k < DLY; k++) pipe_model[k] = 1'b0;

        repeat (3) @(negedge clk);
        // R8: reset state
        check(word_out === '0, "R8", 32'(word_out), 32'd0);
        check(word_strobe === 1'b0, "R8", 32'(word_strobe), 32'd0);
        check(slip_max === 1'b0, "R8", 32'(slip_max), 32'd0);
        rst = 1'b0;

        cur_req = "R2";
        run_words(4, 1'b0);

        // R3 / R5 / R6: single pulses swept through every offset and past the wrap
        cur_req = "R3";
        for (int p = 0; p < J + 3; p++) begin
            if (p >= J - 1) cur_req = "R5";
            run_words(1, 1'b1);
            run_words(6, 1'b0);
        end

        // R4: held request counts once
        cur_req = "R4";
        run_words(3, 1'b1);
        run_words(6, 1'b0);

        // R7: drive offset to J-1, let the flag rise, then clear asynchronously
        cur_req = "R6";
        while (s_model != J - 1) begin
            run_words(1, 1'b1);
            run_words(6, 1'b0);
        end
        check(exp_max === 1'b1, "R6", 32'(exp_max), 32'd1);
        cur_req = "R7";
        cycle(1'b0, 1'b1);
        run_words(6, 1'b0);

        // R9: slip edges on alternate strobes, words use the pre-slip offset
        cur_req = "R9";
        for (int p = 0; p < 2 * J + 1; p++) begin
            run_words(1, 1'b1);
            run_words(1, 1'b0);
        end
        run_words(6, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule